// File: doc/BRIEF.md
# Warp Issue Scheduler

This block picks, in every instruction slot, one warp from a pool of resident warps and presents that warp's program counter and active-lane mask for issue. A warp is a group of lanes that shares one program counter. The scheduler dispatches whole warps, never single lanes. Each warp keeps a stored waiting flag. A per-warp stall input also comes from outside the block, for example for a pending memory access or a barrier. A warp may be picked when it is neither waiting nor stalled and at least one of its lanes is active. A divergent warp keeps issuing with some lanes switched off.

The choice among eligible warps is round-robin, starting with the warp after the one issued last. A change of warp between slots costs no idle cycles. After a warp issues, its stored program counter moves on by one instruction. A simple write port loads a warp's program counter, mask and waiting flag. Computing divergence masks, decode and execution belong to other blocks.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is asserted and after it is released, every warp's mask, program counter and waiting flag are zero. issueValid therefore stays low until a nonzero mask is written.
- R2: A warp is eligible only when its waiting flag is 0, its stallIn bit is 0 and its active mask is not all zero. Only an eligible warp is ever issued.
- R3: The issued warp is the first eligible warp found when scanning upward from (last issued warp + 1), wrapping from NUM_WARPS-1 to 0. After reset the scan starts at warp 0.
- R4: In a slot where no warp is eligible, issueValid is low and the last-issued pointer is left unchanged.
- R5: issuePc and issueMask are the stored program counter and mask of the warp named by issueWarp, in the same slot.
- R6: A warp that issues has its stored program counter increased by PC_STEP (default 4) in the next slot.
- R7: When updEn is high, the warp named by updWarp takes updPc, updMask and updWait at the clock edge, and the new values are visible from the next slot. If that warp issues in the same cycle, the written PC replaces the incremented one.
- R8: Consecutive slots can issue different warps with no idle slot between them. Whenever any warp is eligible, issueValid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stallIn | input | NUM_WARPS | Per-warp external stall, 1 = not eligible this slot |
| updEn | input | 1 | Write strobe for the update port |
| updWarp | input | WID_W | Warp index to write |
| updPc | input | PC_W | New program counter |
| updMask | input | LANES | New active-lane mask |
| updWait | input | 1 | New waiting flag |
| issueValid | output | 1 | A warp is issued this slot |
| issueWarp | output | WID_W | Index of the issued warp |
| issuePc | output | PC_W | Program counter of the issued warp |
| issueMask | output | LANES | Active-lane mask of the issued warp |

## Verification
The first directed pattern has every warp eligible except one with a zero mask and one with its waiting flag set. It separates a true round-robin rotation that skips exactly those two warps from a fixed-priority picker. A fully stalled slot shows whether the idle case keeps the rotation pointer. A write to the warp being picked in that same slot shows whether the written PC or the incremented PC survives. Random slots then mix sparse and dense stall patterns, zero masks and waiting flags with frequent writes. The bench checks the warp index, PC and mask against a behavioural model in every slot, which exposes wrap-around and pointer-update errors.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  localparam int PICK_MAX_W = 8;

  typedef struct packed {
    logic                  issueEn;
    logic [PICK_MAX_W-1:0] pick;
  } schedStrobe_t;
endpackage

// File: rtl/wsched_ctrl.sv
module wsched_ctrl
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int WID_W     = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_WARPS-1:0] eligVec,
  output schedStrobe_t         strobe
);
  localparam logic [WID_W-1:0] LAST_INIT = WID_W'(NUM_WARPS - 1);

  logic [WID_W-1:0] lastWarp;
  logic [WID_W-1:0] pickIdx;
  logic             found;
  int               cand;

  always_comb begin
    found   = 1'b0;
    pickIdx = '0;
    cand    = 0;
    for (int off = 1; off <= NUM_WARPS; off++) begin
      cand = int'(lastWarp) + off;
      if (cand >= NUM_WARPS) cand = cand - NUM_WARPS;
      if (!found && eligVec[cand]) begin
        found   = 1'b1;
        pickIdx = WID_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      lastWarp <= LAST_INIT;
    else if (found) lastWarp <= pickIdx;
  end

  always_comb begin
    strobe.issueEn = found;
    strobe.pick    = PICK_MAX_W'(pickIdx);
  end

  // R4
  idle_when_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eligVec == '0) |-> !strobe.issueEn);

  // R8
  busy_when_any_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eligVec != '0) |-> strobe.issueEn);

  // R3
  rr_rotate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issueEn && $past(strobe.issueEn) && ($countones(eligVec) > 1))
      |-> (strobe.pick != $past(strobe.pick)));
endmodule

// File: rtl/wsched_dp.sv
module wsched_dp
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int LANES     = 32,
  parameter int PC_W      = 32,
  parameter int PC_STEP   = 4,
  parameter int WID_W     = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_WARPS-1:0] stallIn,
  input  logic                 updEn,
  input  logic [WID_W-1:0]     updWarp,
  input  logic [PC_W-1:0]      updPc,
  input  logic [LANES-1:0]     updMask,
  input  logic                 updWait,
  input  schedStrobe_t         strobe,
  output logic [NUM_WARPS-1:0] eligVec,
  output logic [PC_W-1:0]      issuePc,
  output logic [LANES-1:0]     issueMask
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  logic [PC_W-1:0]  pcReg   [NUM_WARPS];
  logic [LANES-1:0] maskReg [NUM_WARPS];
  logic             waitReg [NUM_WARPS];
  logic [WID_W-1:0] pickIdx;

  assign pickIdx = strobe.pick[WID_W-1:0];

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
    logic hitIssue, hitUpd;
    assign hitIssue   = strobe.issueEn && (int'(strobe.pick) == g);
    assign hitUpd     = updEn && (updWarp == WID_W'(g));
    assign eligVec[g] = !waitReg[g] && !stallIn[g] && (maskReg[g] != '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pcReg[g]   <= '0;
        maskReg[g] <= '0;
        waitReg[g] <= 1'b0;
      end else if (hitUpd) begin
        pcReg[g]   <= updPc;
        maskReg[g] <= updMask;
        waitReg[g] <= updWait;
      end else if (hitIssue) begin
        pcReg[g]   <= pcReg[g] + STEP;
      end
    end
  end

  assign issuePc   = pcReg[pickIdx];
  assign issueMask = maskReg[pickIdx];

  // R2
  pick_eligible_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueEn |-> (eligVec[pickIdx] && (issueMask != '0)));

  // R6
  pc_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issueEn && !(updEn && (updWarp == pickIdx)))
      |=> (pcReg[$past(pickIdx)] == $past(issuePc) + STEP));

  // R7
  upd_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updEn && (int'(updWarp) < NUM_WARPS))
      |=> (maskReg[$past(updWarp)] == $past(updMask)
           && pcReg[$past(updWarp)] == $past(updPc)));
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int LANES     = 32,
  parameter int PC_W      = 32,
  parameter int PC_STEP   = 4,
  parameter int WID_W     = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_WARPS-1:0] stallIn,
  input  logic                 updEn,
  input  logic [WID_W-1:0]     updWarp,
  input  logic [PC_W-1:0]      updPc,
  input  logic [LANES-1:0]     updMask,
  input  logic                 updWait,
  output logic                 issueValid,
  output logic [WID_W-1:0]     issueWarp,
  output logic [PC_W-1:0]      issuePc,
  output logic [LANES-1:0]     issueMask
);
  schedStrobe_t         strobe;
  logic [NUM_WARPS-1:0] eligVec;

  wsched_ctrl #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .eligVec(eligVec), .strobe(strobe)
  );

  wsched_dp #(
    .NUM_WARPS(NUM_WARPS), .LANES(LANES), .PC_W(PC_W),
    .PC_STEP(PC_STEP), .WID_W(WID_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stallIn(stallIn),
    .updEn(updEn), .updWarp(updWarp), .updPc(updPc),
    .updMask(updMask), .updWait(updWait), .strobe(strobe),
    .eligVec(eligVec), .issuePc(issuePc), .issueMask(issueMask)
  );

  assign issueValid = strobe.issueEn;
  assign issueWarp  = strobe.pick[WID_W-1:0];

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> !issueValid);
endmodule

// File: tb/warp_issue_sched_tb.sv
module warp_issue_sched_tb;
  localparam int NW = 24, LN = 32, PW = 32, ST = 4, WW = 5;

  logic          clk = 1'b0, rstN = 1'b0;
  logic [NW-1:0] stallIn = '0;
  logic          updEn = 1'b0, updWait = 1'b0;
  logic [WW-1:0] updWarp = '0;
  logic [PW-1:0] updPc = '0;
  logic [LN-1:0] updMask = '0;
  logic          issueValid;
  logic [WW-1:0] issueWarp;
  logic [PW-1:0] issuePc;
  logic [LN-1:0] issueMask;

  warp_issue_sched u_dut (
    .clk(clk), .rstN(rstN), .stallIn(stallIn), .updEn(updEn),
    .updWarp(updWarp), .updPc(updPc), .updMask(updMask), .updWait(updWait),
    .issueValid(issueValid), .issueWarp(issueWarp),
    .issuePc(issuePc), .issueMask(issueMask)
  );

  always #5 clk = ~clk;

  logic [PW-1:0] mPc   [NW];
  logic [LN-1:0] mMask [NW];
  bit            mWait [NW];
  int            mLast;
  int            nChk = 0, nFail = 0;
  bit            done = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expPick(logic [NW-1:0] st);
    for (int off = 1; off <= NW; off++) begin
      int c = (mLast + off) % NW;
      if (!mWait[c] && !st[c] && mMask[c] != '0) return c;
    end
    return -1;
  endfunction

  // one slot: drive, check, advance the model
  task automatic slot(logic [NW-1:0] st, bit ue, int uw, logic [PW-1:0] upc,
                      logic [LN-1:0] um, bit uwt);
    int p;
    @(negedge clk);
    stallIn = st; updEn = ue; updWarp = WW'(uw);
    updPc = upc; updMask = um; updWait = uwt;
    #1;
    p = expPick(st);
    chk("R2/R4/R8 issueValid", 64'(issueValid), 64'(p >= 0));
    if (p >= 0) begin
      chk("R3 issueWarp", 64'(issueWarp), 64'(p));
      chk("R5/R6/R7 issuePc", 64'(issuePc), 64'(mPc[p]));
      chk("R5/R7 issueMask", 64'(issueMask), 64'(mMask[p]));
      mPc[p] = mPc[p] + ST;
      mLast  = p;
    end
    if (ue) begin
      mPc[uw] = upc; mMask[uw] = um; mWait[uw] = uwt;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    for (int i = 0; i < NW; i++) begin
      mPc[i] = '0; mMask[i] = '0; mWait[i] = 0;
    end
    mLast = NW - 1;
    repeat (3) @(negedge clk);
    #1 chk("R1 issueValid in reset", 64'(issueValid), 64'd0);
    rstN = 1'b1;
    // R1: nothing eligible after reset release
    slot('0, 0, 0, '0, '0, 0);
    slot('0, 0, 0, '0, '0, 0);
    // load all warps; warp 5 zero mask, warp 7 waiting (R2)
    for (int w = 0; w < NW; w++)
      slot('1, 1, w, PW'(w * 256), (w == 5) ? '0 : ~LN'(w), (w == 7));
    // R8: all eligible, rotation skipping 5 and 7
    for (int i = 0; i < 50; i++) slot('0, 0, 0, '0, '0, 0);
    // R4: everything stalled, pointer must hold
    slot('1, 0, 0, '0, '0, 0);
    slot('1, 0, 0, '0, '0, 0);
    // R7: write the warp picked in this very slot
    begin
      int p = expPick('0);
      slot('0, 1, p, 32'hABCD_0000, 32'h0000_FFFF, 0);
      for (int i = 0; i < NW; i++) slot('0, 0, 0, '0, '0, 0);
    end
    // R2: release waiting warp 7, then clear warp 3's mask
    slot('0, 1, 7, 32'h700, 32'h1, 0);
    slot('0, 1, 3, 32'h300, '0, 0);
    for (int i = 0; i < NW; i++) slot('0, 0, 0, '0, '0, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [NW-1:0] st;
      logic [LN-1:0] um;
      case ($urandom % 3)
        0: st = NW'($urandom) & NW'($urandom) & NW'($urandom);
        1: st = NW'($urandom);
        default: st = NW'($urandom) | NW'($urandom) | NW'($urandom);
      endcase
      um = ($urandom % 5 == 0) ? '0 : LN'($urandom);
      slot(st, ($urandom % 3) == 0, int'($urandom % NW), PW'($urandom),
           um, ($urandom % 4) == 0);
    end
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule